// File: doc/BRIEF.md
# Serial Panel Command/Data Transmitter

This block feeds a small graphic display panel over a five-wire synchronous serial link: a panel power enable, an active-low select, a serial clock that rests high, one serial data line, and a flag that marks each byte as a command or as display data. A host hands it entries over a valid/ready stream. Each entry carries one byte, a command/data tag and an end-of-section marker. The block shifts every byte out most significant bit first with exactly eight clock pulses. Under one select window it frames a section of command bytes followed by the data bytes that belong to them. A lone command, such as a sleep request, is simply a one-entry section.

The host raises the panel enable with a power-on request and drops it with a standby request. While the enable is low every link wire rests at its idle level and no entry is taken. The serial bit rate comes from a half-period input measured in system clocks, and values below two are raised to two. Back-pressure rule: an entry transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the panel is enabled and the block is either idle or paused between two bytes of an open section. The host may hold an entry for any number of cycles and may leave gaps between entries. The fields must stay steady while `in_valid` is high and `in_ready` is low.

Top module: `lcd_serial_tx`

## Requirements
- R1: `lcd_en` goes high one cycle after an edge that sees `pwr_on_req` high and `pwr_off_req` low. It goes low one cycle after an edge that sees `pwr_off_req` high; standby wins when both are high. Reset value is low.
- R2: While `lcd_en` is low, `lcd_sel_n`=1, `lcd_sck`=1, `lcd_sdo`=0, `lcd_dc`=1 and `in_ready`=0, and an offered entry is neither taken nor sent.
- R3: Select falls on the cycle after an entry is taken from the idle state, and it stays low for H cycles before the first clock fall of that byte, where H is the effective half period. After the last rising clock edge of a section, select returns high.
- R4: The clock rests high. Every byte produces exactly eight low pulses, and the clock is only low while select is low.
- R5: Bits leave most significant first. `lcd_sdo` changes only together with a clock fall, or when a section closes. It is stable across every rising clock edge.
- R6: `lcd_dc` is 0 for a command byte and 1 for a data byte, which is the entry's `in_is_data` bit. It takes the new byte's value on that byte's first clock fall, never earlier. It rests at 1 whenever select is high.
- R7: H = max(`div_half`, 2) system clocks, sampled when the entry is taken. Every clock low phase and every high phase within a byte lasts H cycles.
- R8: `in_ready` is low from the cycle after a byte is taken until that byte's last high phase completes, and also during the closing gap.
- R9: After a byte marked end-of-section, select stays high for at least 2H cycles before `in_ready` returns. If the next entry is already offered, the next select fall comes 2H+1 cycles after the rise.
- R10: Within a section, select stays low and the clock stays high between bytes for as long as the host pauses. The next byte's first clock fall comes on the cycle after it is taken.
- R11: A standby request during a byte abandons it. The link goes idle in the cycle `lcd_en` falls, and after a new power-on the next entry is sent in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_on_req | input | 1 | Request to enable the panel |
| pwr_off_req | input | 1 | Request to put the panel in standby |
| div_half | input | DIV_W | Serial half period in system clocks (minimum 2 applied) |
| in_valid | input | 1 | Entry offered by the host |
| in_ready | output | 1 | Block can take an entry this cycle |
| in_byte | input | BITS | Byte to send |
| in_is_data | input | 1 | 1 = display data, 0 = command |
| in_last | input | 1 | Entry closes the current section |
| lcd_en | output | 1 | Panel enable |
| lcd_sel_n | output | 1 | Active-low select |
| lcd_sck | output | 1 | Serial clock, idles high |
| lcd_sdo | output | 1 | Serial data, sampled by the panel on the clock rise |
| lcd_dc | output | 1 | Command (0) / data (1) flag |

## Verification
The embedded assertions check, on every cycle, that the clock is only low under an active select, that data holds across each rising edge, that the flag changes only on a clock fall or with select high, that no byte exceeds eight pulses, that ready is low while the clock is low, that the link is idle while disabled, and that enable follows the power requests. Only the bench scenarios can show that the bytes decoded at the clock rises equal the offered entries in order, with their tags. They also show the exact setup, half-period and closing-gap lengths for several divider settings, the clamping of small divider values, pauses inside a section, and clean recovery after standby cuts a byte short.

// File: rtl/lcd_tx_pkg.sv
package lcd_tx_pkg;

  // smallest half period allowed on the serial clock, in system clocks
  localparam int MIN_HALF = 2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // select high, waiting for the first entry of a section
    ST_SETUP = 3'd1,  // select low, clock high, before the first fall
    ST_LOW   = 3'd2,  // clock low phase of one bit
    ST_HIGH  = 3'd3,  // clock high phase of one bit
    ST_WAIT  = 3'd4,  // between bytes of an open section
    ST_GUARD = 3'd5   // select high gap after a section closes
  } tx_state_e;

endpackage

// File: rtl/lcd_tx_power.sv
module lcd_tx_power (
  input  logic clk,
  input  logic rst_n,
  input  logic on_req,
  input  logic off_req,
  output logic en
);

  always_ff @(posedge clk) begin
    if (!rst_n)        en <= 1'b0;
    else if (off_req)  en <= 1'b0;
    else if (on_req)   en <= 1'b1;
  end

endmodule

// File: rtl/lcd_tx_timer.sv
module lcd_tx_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/lcd_tx_engine.sv
module lcd_tx_engine
  import lcd_tx_pkg::*;
#(
  parameter int BITS  = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_half,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BITS-1:0]  in_byte,
  input  logic             in_is_data,
  input  logic             in_last,
  output logic             sel_q,
  output logic             sck_q,
  output logic             sdo_q,
  output logic             dc_q
);

  localparam int IDX_W = (BITS > 1) ? $clog2(BITS) : 1;
  localparam int TW    = DIV_W + 1;

  tx_state_e           st_q, st_d;
  logic [BITS-1:0]     sh_q, sh_d;
  logic [IDX_W-1:0]    bit_q, bit_d;
  logic                tag_q, tag_d, last_q, last_d;
  logic [DIV_W-1:0]    half_q, half_d;
  logic                sel_d, sck_d, sdo_d, dc_d;
  logic                t_load, t_zero;
  logic [TW-1:0]       t_val;
  logic [DIV_W-1:0]    eff_half;
  logic                accept;

  assign eff_half = (div_half < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : div_half;
  assign in_ready = en && ((st_q == ST_IDLE) || (st_q == ST_WAIT));
  assign accept   = in_valid && in_ready;

  lcd_tx_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    tag_d  = tag_q;
    last_d = last_q;
    half_d = half_q;
    sel_d  = sel_q;
    sck_d  = sck_q;
    sdo_d  = sdo_q;
    dc_d   = dc_q;
    t_load = 1'b0;
    t_val  = '0;
    if (!en) begin
      st_d  = ST_IDLE;
      sel_d = 1'b1;
      sck_d = 1'b1;
      sdo_d = 1'b0;
      dc_d  = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            sh_d   = in_byte;
            tag_d  = in_is_data;
            last_d = in_last;
            half_d = eff_half;
            st_d   = ST_SETUP;
            t_load = 1'b1;
            t_val  = TW'(eff_half) - TW'(1);
            sel_d  = 1'b0;
          end
        end
        ST_SETUP: begin
          if (t_zero) begin
            st_d   = ST_LOW;
            t_load = 1'b1;
            t_val  = TW'(half_q) - TW'(1);
            sck_d  = 1'b0;
            sdo_d  = sh_q[BITS-1];
            dc_d   = tag_q;
            bit_d  = IDX_W'(BITS - 1);
          end
        end
        ST_LOW: begin
          if (t_zero) begin
            st_d   = ST_HIGH;
            t_load = 1'b1;
            t_val  = TW'(half_q) - TW'(1);
            sck_d  = 1'b1;
          end
        end
        ST_HIGH: begin
          if (t_zero) begin
            if (bit_q == '0) begin
              if (last_q) begin
                st_d   = ST_GUARD;
                t_load = 1'b1;
                t_val  = {half_q, 1'b0} - TW'(1);
                sel_d  = 1'b1;
                sdo_d  = 1'b0;
                dc_d   = 1'b1;
              end else begin
                st_d = ST_WAIT;
              end
            end else begin
              st_d   = ST_LOW;
              t_load = 1'b1;
              t_val  = TW'(half_q) - TW'(1);
              bit_d  = bit_q - IDX_W'(1);
              sh_d   = sh_q << 1;
              sdo_d  = sh_q[BITS-2];
              sck_d  = 1'b0;
            end
          end
        end
        ST_WAIT: begin
          if (accept) begin
            sh_d   = in_byte;
            tag_d  = in_is_data;
            last_d = in_last;
            half_d = eff_half;
            st_d   = ST_LOW;
            t_load = 1'b1;
            t_val  = TW'(eff_half) - TW'(1);
            sck_d  = 1'b0;
            sdo_d  = in_byte[BITS-1];
            dc_d   = in_is_data;
            bit_d  = IDX_W'(BITS - 1);
          end
        end
        ST_GUARD: begin
          if (t_zero) st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      bit_q  <= '0;
      tag_q  <= 1'b1;
      last_q <= 1'b0;
      half_q <= DIV_W'(MIN_HALF);
      sel_q  <= 1'b1;
      sck_q  <= 1'b1;
      sdo_q  <= 1'b0;
      dc_q   <= 1'b1;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      tag_q  <= tag_d;
      last_q <= last_d;
      half_q <= half_d;
      sel_q  <= sel_d;
      sck_q  <= sck_d;
      sdo_q  <= sdo_d;
      dc_q   <= dc_d;
    end
  end

  // checker state: clock falls seen since the latest accepted byte
  logic             sck_prev;
  logic [IDX_W+1:0] fall_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_prev <= 1'b1;
      fall_cnt <= '0;
    end else begin
      sck_prev <= sck_q;
      if (accept)                 fall_cnt <= '0;
      else if (sck_prev && !sck_q) fall_cnt <= fall_cnt + 1'b1;
    end
  end

  // R4
  sck_under_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_q |-> !sel_q);

  // R4
  pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_cnt <= (IDX_W+2)'(BITS));

  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) |-> $stable(sdo_q));

  // R6
  dc_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dc_q) |-> (!sck_q || sel_q));

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_q |-> !in_ready);

endmodule

// File: rtl/lcd_serial_tx.sv
module lcd_serial_tx #(
  parameter int BITS  = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on_req,
  input  logic             pwr_off_req,
  input  logic [DIV_W-1:0] div_half,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BITS-1:0]  in_byte,
  input  logic             in_is_data,
  input  logic             in_last,
  output logic             lcd_en,
  output logic             lcd_sel_n,
  output logic             lcd_sck,
  output logic             lcd_sdo,
  output logic             lcd_dc
);

  logic en;
  logic sel_q, sck_q, sdo_q, dc_q;

  lcd_tx_power u_power (
    .clk     (clk),
    .rst_n   (rst_n),
    .on_req  (pwr_on_req),
    .off_req (pwr_off_req),
    .en      (en)
  );

  lcd_tx_engine #(.BITS(BITS), .DIV_W(DIV_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .div_half   (div_half),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_byte    (in_byte),
    .in_is_data (in_is_data),
    .in_last    (in_last),
    .sel_q      (sel_q),
    .sck_q      (sck_q),
    .sdo_q      (sdo_q),
    .dc_q       (dc_q)
  );

  // idle levels are forced the moment the enable drops
  assign lcd_en    = en;
  assign lcd_sel_n = en ? sel_q : 1'b1;
  assign lcd_sck   = en ? sck_q : 1'b1;
  assign lcd_sdo   = en ? sdo_q : 1'b0;
  assign lcd_dc    = en ? dc_q  : 1'b1;

  // R1
  pwr_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on_req && !pwr_off_req) |=> lcd_en);

  // R1
  pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_req |=> !lcd_en);

  // R2
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_en |-> (lcd_sel_n && lcd_sck && !lcd_sdo && lcd_dc && !in_ready));

endmodule

// File: tb/lcd_serial_tx_bench.sv
`timescale 1ns/1ps
module lcd_serial_tx_bench;

  localparam int BITS  = 8;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pwr_on_req = 1'b0, pwr_off_req = 1'b0;
  logic [DIV_W-1:0] div_half = 8'd2;
  logic             in_valid = 1'b0;
  logic [BITS-1:0]  in_byte = '0;
  logic             in_is_data = 1'b0, in_last = 1'b0;
  logic             in_ready, lcd_en, lcd_sel_n, lcd_sck, lcd_sdo, lcd_dc;

  always #2.5 clk = ~clk;

  lcd_serial_tx #(.BITS(BITS), .DIV_W(DIV_W)) u_lcd_serial_tx (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .div_half(div_half), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_is_data(in_is_data), .in_last(in_last),
    .lcd_en(lcd_en), .lcd_sel_n(lcd_sel_n), .lcd_sck(lcd_sck),
    .lcd_sdo(lcd_sdo), .lcd_dc(lcd_dc));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // ---------------- behavioural reference, advanced on each rising edge
  int m_ph;            // 0 idle,1 setup,2 low,3 high,4 wait,5 gap
  int m_cnt, m_left, m_half;
  bit m_en, m_tag, m_last, m_sel, m_sck, m_sdo, m_dc;
  bit [BITS-1:0] m_byte;

  function automatic bit m_ready();
    return m_en && (m_ph == 0 || m_ph == 4);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_en = 0; m_sel = 1; m_sck = 1; m_sdo = 0; m_dc = 1;
      m_left = 0; m_half = 2; m_tag = 1; m_last = 0; m_byte = '0;
    end else begin
      bit take, loaded, done_wait;
      int h;
      take = in_valid && m_ready();
      h = (int'(div_half) < 2) ? 2 : int'(div_half);
      loaded = 0;
      done_wait = (m_cnt == 0);
      if (!m_en) begin
        m_ph = 0; m_sel = 1; m_sck = 1; m_sdo = 0; m_dc = 1;
      end else if (m_ph == 0) begin
        if (take) begin
          m_byte = in_byte; m_tag = in_is_data; m_last = in_last; m_half = h;
          m_ph = 1; m_cnt = h - 1; loaded = 1; m_sel = 0;
        end
      end else if (m_ph == 1) begin
        if (done_wait) begin
          m_ph = 2; m_cnt = m_half - 1; loaded = 1; m_left = BITS - 1;
          m_sck = 0; m_sdo = m_byte[BITS-1]; m_dc = m_tag;
        end
      end else if (m_ph == 2) begin
        if (done_wait) begin m_ph = 3; m_cnt = m_half - 1; loaded = 1; m_sck = 1; end
      end else if (m_ph == 3) begin
        if (done_wait) begin
          if (m_left == 0) begin
            if (m_last) begin
              m_ph = 5; m_cnt = 2 * m_half - 1; loaded = 1; m_sel = 1; m_sdo = 0; m_dc = 1;
            end else m_ph = 4;
          end else begin
            m_left--; m_ph = 2; m_cnt = m_half - 1; loaded = 1;
            m_sck = 0; m_sdo = m_byte[m_left];
          end
        end
      end else if (m_ph == 4) begin
        if (take) begin
          m_byte = in_byte; m_tag = in_is_data; m_last = in_last; m_half = h;
          m_ph = 2; m_cnt = h - 1; loaded = 1; m_left = BITS - 1;
          m_sck = 0; m_sdo = in_byte[BITS-1]; m_dc = in_is_data;
        end
      end else begin
        if (done_wait) m_ph = 0;
      end
      if (!loaded && m_cnt > 0) m_cnt--;
      if (pwr_off_req) m_en = 0;
      else if (pwr_on_req) m_en = 1;
    end
  end

  // ---------------- per-cycle comparison and link decoder, on falling edges
  int cyc = 0;
  bit p_sel = 1, p_sck = 1;
  int t_sel_fall, t_sck_fall, t_sel_rise;
  int last_setup = -1, last_low = -1, last_high = -1, last_gap = -1;
  bit first_fall_pending = 0;
  bit [BITS-1:0] rx_sh;
  int rx_n = 0;
  int rx_q[$];
  int exp_q[$];
  int sel_rises = 0;
  int busy_ready_hits = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      int ok;
      ok = (lcd_en == m_en) &&
           (lcd_sel_n == (m_en ? m_sel : 1'b1)) &&
           (lcd_sck   == (m_en ? m_sck : 1'b1)) &&
           (lcd_sdo   == (m_en ? m_sdo : 1'b0)) &&
           (lcd_dc    == (m_en ? m_dc  : 1'b1)) &&
           (in_ready  == m_ready());
      // R4 R5 R6 R8 cycle match against the reference
      chk("R4/R5/R6/R8 cycle", ok, 1);
      if (!lcd_sck && in_ready) busy_ready_hits++;
      if (p_sel && !lcd_sel_n) begin
        t_sel_fall = cyc; first_fall_pending = 1;
        if (sel_rises > 0) last_gap = cyc - t_sel_rise;
      end
      if (!p_sel && lcd_sel_n) begin t_sel_rise = cyc; sel_rises++; rx_n = 0; end
      if (p_sck && !lcd_sck) begin
        if (first_fall_pending) begin last_setup = cyc - t_sel_fall; first_fall_pending = 0; end
        if (rx_n > 0) last_high = cyc - t_sck_fall - last_low;
        t_sck_fall = cyc;
      end
      if (!p_sck && lcd_sck && !lcd_sel_n) begin
        last_low = cyc - t_sck_fall;
        rx_sh = {rx_sh[BITS-2:0], lcd_sdo};
        rx_n++;
        if (rx_n == BITS) begin rx_q.push_back({lcd_dc, rx_sh}); rx_n = 0; end
      end
      p_sel = lcd_sel_n; p_sck = lcd_sck;
    end
  end

  // ---------------- stimulus helpers (called on a falling edge)
  task automatic send(input logic [7:0] b, input bit d, input bit l, input bit keep);
    in_valid = 1; in_byte = b; in_is_data = d; in_last = l;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    if (keep) exp_q.push_back({d, b});
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_quiet();
    while (!(in_ready && lcd_sel_n)) @(negedge clk);
  endtask

  task automatic power(input bit on);
    if (on) pwr_on_req = 1; else pwr_off_req = 1;
    @(negedge clk);
    pwr_on_req = 0; pwr_off_req = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    wrap_up();
  end

  initial begin
    idle_wait(3);
    rst_n = 1;
    idle_wait(1);
    // R1 R2 reset state
    chk("R1 reset enable", lcd_en, 0);
    chk("R2 idle levels", {lcd_sel_n, lcd_sck, lcd_sdo, lcd_dc}, 4'b1101);
    chk("R2 ready while off", in_ready, 0);
    // R2 entry offered while disabled is ignored
    in_valid = 1; in_byte = 8'h5A; in_is_data = 0; in_last = 1;
    idle_wait(20);
    chk("R2 no activity while off", {lcd_sel_n, lcd_sck}, 2'b11);
    in_valid = 0;
    chk("R2 nothing decoded", rx_q.size(), 0);

    power(1);
    chk("R1 enable after on", lcd_en, 1);

    // lone command, H = 2
    div_half = 8'd2;
    send(8'hA5, 0, 1, 1);
    wait_quiet();
    chk("R3 setup before first fall", last_setup, 2);
    chk("R7 low phase H=2", last_low, 2);
    chk("R7 high phase H=2", last_high, 2);
    chk("R4 one byte decoded", rx_q.size(), 1);

    // divider below minimum clamps to 2
    div_half = 8'd0;
    send(8'h3C, 0, 1, 1);
    wait_quiet();
    chk("R7 clamped low phase", last_low, 2);

    // section of commands then data, H = 5, with a pause between bytes
    div_half = 8'd5;
    begin
      int rises0;
      rises0 = sel_rises;
      send(8'h2A, 0, 0, 1);
      send(8'h00, 0, 0, 1);
      while (!in_ready) @(negedge clk);
      idle_wait(13);
      // R10 select low and clock high during the pause
      chk("R10 pause levels", {lcd_sel_n, lcd_sck}, 2'b01);
      send(8'h11, 1, 0, 1);
      send(8'h82, 1, 0, 1);
      send(8'hFF, 1, 0, 1);
      send(8'h14, 1, 1, 1);
      wait_quiet();
      chk("R10 one select window", sel_rises - rises0, 1);
      chk("R3 setup H=5", last_setup, 5);
      chk("R7 low phase H=5", last_low, 5);
      chk("R7 high phase H=5", last_high, 5);
    end

    // two sections back to back with the next entry already offered, H = 3
    div_half = 8'd3;
    send(8'hB0, 0, 0, 1);
    send(8'h01, 1, 1, 1);
    send(8'hC4, 0, 1, 1);
    wait_quiet();
    chk("R9 gap between sections", last_gap, 7);
    chk("R8 ready never high while clock low", busy_ready_hits, 0);

    // standby in the middle of a byte
    div_half = 8'd4;
    send(8'hE7, 1, 1, 0);
    idle_wait(10);
    pwr_off_req = 1;
    @(negedge clk);
    pwr_off_req = 0;
    chk("R11 enable low", lcd_en, 0);
    chk("R11 idle at once", {lcd_sel_n, lcd_sck, lcd_sdo, lcd_dc, in_ready}, 5'b11010);
    idle_wait(5);
    power(1);
    send(8'h69, 0, 1, 1);
    wait_quiet();

    // R5 R6 decoded stream matches offered entries, order and tags
    chk("R5 decoded count", rx_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
      chk("R5/R6 decoded entry", rx_q[i], exp_q[i]);

    wrap_up();
  end

endmodule